// File: doc/BRIEF.md
# Serial Command Front End for a Four-Channel Wiper Controller

This block is the slave side of a four-wire serial link that controls four wiper counters and their banks of stored settings. A host lowers the select line and sends an address byte. Then it sends a command byte and, depending on the command, either one data byte, nothing more, or an open-ended run of step pulses. Up to four devices can share one select line. The first byte names a fixed device type and a two-bit board address, and only the device whose strap pins match acts on the rest of the frame.

The decoder works in one system clock domain. The serial clock, select, data-in and pause pins are re-timed through two-stage synchronizers, and edges are detected on the re-timed copies. Every completed command becomes a one-cycle action pulse. The pulse carries an action code, the channel and stored-slot selects, a data field and an all-channels flag, and the surrounding register bank executes it. For read commands the decoder captures the value the bank presents for the selected channel and slot, and shifts it out on the serial output. The output enable is high only while that reply byte is on the wire.

Top module: `spi_frame_decoder`

## Requirements
- R1: The data input is taken on each rising serial clock, most significant bit first. The serial output changes only after a falling serial clock.
- R2: After reset, no frame is accepted until the select line has been seen high and then low. Clocking while select stays low from reset produces no action.
- R3: The first byte of a frame must read 0101 in bits 7:4, 00 in bits 3:2 and the strap value in bits 1:0. Otherwise the rest of the frame produces no action and no output.
- R4: In the command byte, bits 7:4 are the opcode, bits 3:2 the slot select and bits 1:0 the channel select. Action pulses carry these on `regsel_o` and `chan_o`.
- R5: Opcode 1101 issues action code 2 (slot to wiper) and opcode 1110 issues action code 3 (wiper to slot), with `act_all_o` low. Opcode 0001 issues code 2 and opcode 1000 issues code 3, with `act_all_o` high. Each issues one pulse right after the command byte.
- R6: Opcode 1010 issues action code 0 (load wiper) and opcode 1100 issues action code 1 (load slot) after the third byte. `data_o` holds the low six bits of that byte.
- R7: Opcode 1001 (wiper) and opcode 1011 (slot) return 00 followed by the six-bit value, MSB first, during the third byte. `so_oe_o` is high only then and is low while select is high.
- R8: Opcode 0101 returns seven zero bits followed by the write-busy input in the last bit.
- R9: After opcode 0010, each further rising serial clock issues action code 4 (step up) if the data input is 1 and code 5 (step down) if it is 0. This continues until select rises.
- R10: While the pause input is low, serial clock edges are ignored and the frame position and shift contents are kept. The frame resumes when pause goes high.
- R11: Opcodes not listed above, and frames cut off by select rising part-way through a byte, produce no action.
- R12: Every action is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause, active low |
| strap_i | input | 2 | Board address straps |
| wip_i | input | 1 | Write-busy flag returned by the status read |
| wiper_rd_i | input | 6 | Wiper value of channel `chan_o` |
| dreg_rd_i | input | 6 | Stored slot `regsel_o` of channel `chan_o` |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |
| act_o | output | 1 | Action pulse |
| act_kind_o | output | 3 | Action code (0 to 5) |
| act_all_o | output | 1 | Action applies to all channels |
| chan_o | output | 2 | Channel select |
| regsel_o | output | 2 | Slot select |
| data_o | output | 6 | Data for load actions |

## Verification
A corrupted bit counter or frame phase shows up at once as a wrong or missing action pulse, at the latest three system cycles after the serial edge that completes the affected byte. The reference model flags it on that clock. A wrong reply shift state shows on the serial output at the next sampled bit. A pause that fails to freeze state corrupts the data field of the next load action. A missed address or opcode check gives an action pulse in a frame that should be silent.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ACT_LD_WIPER = 3'd0,
    ACT_LD_SLOT  = 3'd1,
    ACT_SLOT2W   = 3'd2,
    ACT_W2SLOT   = 3'd3,
    ACT_STEP_UP  = 3'd4,
    ACT_STEP_DN  = 3'd5
  } act_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_STEP, PH_SKIP
  } phase_t;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_SLOT  = 4'b1011;
  localparam logic [3:0] OP_WR_SLOT  = 4'b1100;
  localparam logic [3:0] OP_SLOT2W   = 4'b1101;
  localparam logic [3:0] OP_W2SLOT   = 4'b1110;
  localparam logic [3:0] OP_G_SLOT2W = 4'b0001;
  localparam logic [3:0] OP_G_W2SLOT = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [3:0] OP_STATUS   = 4'b0101;
endpackage

// File: rtl/spi_fd_sync.sv
module spi_fd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] pipe [W];

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pipe[gi] <= '0;
      else     pipe[gi] <= {pipe[gi][STAGES-2:0], d[gi]};
    end
    assign q[gi] = pipe[gi][STAGES-1];
  end
endmodule

// File: rtl/spi_fd_tx.sv
module spi_fd_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] val,
  output logic         so
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign so = sr[W-1];
endmodule

// File: rtl/spi_fd_ctrl.sv
module spi_fd_ctrl
  import spi_fd_pkg::*;
#(
  parameter int          DW      = 6,
  parameter int          CHW     = 2,
  parameter int          RSW     = 2,
  parameter logic [3:0]  DEV_TYPE = 4'b0101
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n_s,
  input  logic           sck_s,
  input  logic           si_s,
  input  logic           hold_s,
  input  logic [CHW-1:0] strap,
  output logic           sck_fall,
  output logic           tx_load,
  output logic           tx_shift,
  output logic           so_oe,
  output logic [3:0]     op,
  output logic           act,
  output logic [2:0]     act_kind,
  output logic           act_all,
  output logic [CHW-1:0] chan,
  output logic [RSW-1:0] regsel,
  output logic [DW-1:0]  data
);
  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  phase_t               phase;
  logic [CNT_W-1:0]     bitcnt;
  logic [BYTE_BITS-1:0] shin;
  logic                 cs_q, sck_q;
  logic                 cs_fall, cs_rise, sck_rise, rd_active;
  logic [BYTE_BITS-1:0] shin_nx;

  assign cs_fall  = cs_q & ~cs_n_s;
  assign cs_rise  = ~cs_q & cs_n_s;
  assign sck_rise = hold_s & ~cs_n_s & ~sck_q & sck_s;
  assign sck_fall = hold_s & ~cs_n_s & sck_q & ~sck_s;
  assign shin_nx  = {shin[BYTE_BITS-2:0], si_s};

  assign rd_active = (phase == PH_DATA) &&
                     (op == OP_RD_WIPER || op == OP_RD_SLOT || op == OP_STATUS);
  assign tx_load   = sck_fall && rd_active && (bitcnt == '0);
  assign tx_shift  = sck_fall && rd_active && (bitcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
      so_oe <= rd_active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shin     <= '0;
      op       <= '0;
      chan     <= '0;
      regsel   <= '0;
      act      <= 1'b0;
      act_kind <= '0;
      act_all  <= 1'b0;
      data     <= '0;
    end else begin
      act <= 1'b0;
      if (cs_rise) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
      end else if (cs_fall) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
      end else if (sck_rise) begin
        unique case (phase)
          PH_ADDR, PH_CMD, PH_DATA: begin
            shin   <= shin_nx;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              if (phase == PH_ADDR) begin
                phase <= (shin_nx[7:4] == DEV_TYPE && shin_nx[3:2] == 2'b00 &&
                          shin_nx[CHW-1:0] == strap) ? PH_CMD : PH_SKIP;
              end else if (phase == PH_CMD) begin
                op      <= shin_nx[7:4];
                regsel  <= shin_nx[3:2];
                chan    <= shin_nx[CHW-1:0];
                act_all <= 1'b0;
                phase   <= PH_SKIP;
                unique case (shin_nx[7:4])
                  OP_SLOT2W, OP_G_SLOT2W: begin
                    act      <= 1'b1;
                    act_kind <= ACT_SLOT2W;
                    act_all  <= (shin_nx[7:4] == OP_G_SLOT2W);
                  end
                  OP_W2SLOT, OP_G_W2SLOT: begin
                    act      <= 1'b1;
                    act_kind <= ACT_W2SLOT;
                    act_all  <= (shin_nx[7:4] == OP_G_W2SLOT);
                  end
                  OP_RD_WIPER, OP_WR_WIPER, OP_RD_SLOT, OP_WR_SLOT, OP_STATUS:
                    phase <= PH_DATA;
                  OP_STEP: phase <= PH_STEP;
                  default: phase <= PH_SKIP;
                endcase
              end else begin
                phase <= PH_SKIP;
                if (op == OP_WR_WIPER || op == OP_WR_SLOT) begin
                  act      <= 1'b1;
                  act_kind <= (op == OP_WR_WIPER) ? ACT_LD_WIPER : ACT_LD_SLOT;
                  data     <= shin_nx[DW-1:0];
                end
              end
            end
          end
          PH_STEP: begin
            act      <= 1'b1;
            act_kind <= si_s ? ACT_STEP_UP : ACT_STEP_DN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
  import spi_fd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 6,
  parameter int CHW         = 2,
  parameter int RSW         = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n_i,
  input  logic           sck_i,
  input  logic           si_i,
  input  logic           hold_n_i,
  input  logic [CHW-1:0] strap_i,
  input  logic           wip_i,
  input  logic [DW-1:0]  wiper_rd_i,
  input  logic [DW-1:0]  dreg_rd_i,
  output logic           so_o,
  output logic           so_oe_o,
  output logic           act_o,
  output logic [2:0]     act_kind_o,
  output logic           act_all_o,
  output logic [CHW-1:0] chan_o,
  output logic [RSW-1:0] regsel_o,
  output logic [DW-1:0]  data_o
);
  localparam int PAD = BYTE_BITS - DW;

  logic [3:0]           pins_s;
  logic                 cs_n_s, sck_s, si_s, hold_s;
  logic                 sck_fall, tx_load, tx_shift;
  logic [3:0]           op;
  logic [BYTE_BITS-1:0] reply;

  spi_fd_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n_i, sck_i, si_i, hold_n_i}),
    .q(pins_s)
  );
  assign {cs_n_s, sck_s, si_s, hold_s} = pins_s;

  spi_fd_ctrl #(.DW(DW), .CHW(CHW), .RSW(RSW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s), .hold_s(hold_s),
    .strap(strap_i),
    .sck_fall(sck_fall), .tx_load(tx_load), .tx_shift(tx_shift),
    .so_oe(so_oe_o), .op(op),
    .act(act_o), .act_kind(act_kind_o), .act_all(act_all_o),
    .chan(chan_o), .regsel(regsel_o), .data(data_o)
  );

  always_comb begin
    unique case (op)
      OP_RD_WIPER: reply = {{PAD{1'b0}}, wiper_rd_i};
      OP_RD_SLOT:  reply = {{PAD{1'b0}}, dreg_rd_i};
      default:     reply = {{(BYTE_BITS-1){1'b0}}, wip_i};
    endcase
  end

  spi_fd_tx #(.W(BYTE_BITS)) u_tx (
    .clk(clk), .rst(rst),
    .load(tx_load), .shift(tx_shift), .val(reply),
    .so(so_o)
  );
endmodule

// File: rtl/spi_fd_checker.sv
module spi_fd_checker (
  input logic       clk,
  input logic       rst,
  input logic       act,
  input logic [2:0] kind,
  input logic       so,
  input logic       so_oe,
  input logic       cs_n,
  input logic       hold_s,
  input logic       si_s,
  input logic       sck_fall
);
  assert_act_single_R12: assert property (@(posedge clk) disable iff (rst)
    act |=> !act);

  assert_so_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(so) |-> $past(sck_fall));

  assert_oe_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe);

  assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    act |-> $past(hold_s));

  assert_step_up_R9: assert property (@(posedge clk) disable iff (rst)
    (act && kind == 3'd4) |-> $past(si_s));

  assert_step_dn_R9: assert property (@(posedge clk) disable iff (rst)
    (act && kind == 3'd5) |-> !$past(si_s));
endmodule

bind spi_frame_decoder spi_fd_checker u_chk (
  .clk(clk), .rst(rst), .act(act_o), .kind(act_kind_o),
  .so(so_o), .so_oe(so_oe_o), .cs_n(cs_n_i),
  .hold_s(hold_s), .si_s(si_s), .sck_fall(sck_fall)
);

// File: tb/sim_spi_frame_decoder.sv
module sim_spi_frame_decoder;
  localparam int HALF = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ADDR_OK = 8'h52;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [5:0] wiper_rd, dreg_rd;
  logic so, so_oe, act, act_all;
  logic [2:0] act_kind;
  logic [1:0] chan, regsel;
  logic [5:0] data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;
  string cur_req = "R2";
  logic [13:0] expq[$];

  always #4 clk = ~clk;

  assign wiper_rd = 6'd10 + 6'd7 * {4'd0, chan};
  assign dreg_rd  = 6'd5 + 6'd16 * {4'd0, chan} + 6'd3 * {4'd0, regsel};

  spi_frame_decoder u0 (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .strap_i(STRAP), .wip_i(wip), .wiper_rd_i(wiper_rd), .dreg_rd_i(dreg_rd),
    .so_o(so), .so_oe_o(so_oe), .act_o(act), .act_kind_o(act_kind), .act_all_o(act_all),
    .chan_o(chan), .regsel_o(regsel), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic expect_act(input int kind, input bit all, input int c, input int r, input int d);
    expq.push_back({3'(kind), all, 2'(c), 2'(r), 6'(d)});
  endtask

  // reference model comparison of the action stream on every clock
  always @(negedge clk) begin
    if (!rst && act) begin
      logic [13:0] e, a, m;
      a = {act_kind, act_all, chan, regsel, data};
      if (expq.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected action"}, int'(a), 0);
      end else begin
        e = expq.pop_front();
        m = 14'b111_1_00_00_000000;
        if (!e[10]) m[9:8] = 2'b11;
        if (e[13:11] inside {3'd1, 3'd2, 3'd3}) m[7:6] = 2'b11;
        if (e[13:11] inside {3'd0, 3'd1}) m[5:0] = 6'h3f;
        chk((a & m) == (e & m), {cur_req, " action fields"}, int'(a & m), int'(e & m));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input bit b, output bit s);
    si = b;
    wait_clk(HALF);
    s = so;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      bit s;
      sck_bit(b[i], s);
      r[i] = s;
    end
  endtask

  task automatic fbegin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic fend();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic drained(input string req);
    wait_clk(4);
    chk(expq.size() == 0, {req, " expected actions all seen"}, expq.size(), 0);
  endtask

  task automatic cmd_frame(input logic [7:0] a, input logic [7:0] c, input bit third,
                           input logic [7:0] d, output logic [7:0] r);
    logic [7:0] x;
    fbegin();
    send_byte(a, x);
    send_byte(c, x);
    r = 8'h00;
    if (third) send_byte(d, r);
    fend();
  endtask

  initial begin
    logic [7:0] r;
    bit s;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // reset state
    chk(act == 1'b0, "R12 reset act", act, 0);
    chk(so_oe == 1'b0, "R7 reset oe", so_oe, 0);

    // R2: select held low since reset, frame must be ignored
    cur_req = "R2";
    send_byte(ADDR_OK, r);
    send_byte(8'hA2, r);
    send_byte(8'h2A, r);
    drained("R2");
    cs_n = 1'b1;
    wait_clk(3 * HALF);

    // R1 R6: load wiper
    cur_req = "R6";
    expect_act(0, 0, 2, 0, 6'h2A);
    cmd_frame(ADDR_OK, 8'hA2, 1, 8'hEA, r);
    drained("R1");

    // R6 R4: load slot, channel 1 slot 3
    expect_act(1, 0, 1, 3, 6'h15);
    cmd_frame(ADDR_OK, 8'hCD, 1, 8'h15, r);
    drained("R6");

    // R3: wrong strap, and nonzero bits 3:2
    cur_req = "R3";
    cmd_frame(8'h51, 8'hA2, 1, 8'h2A, r);
    cmd_frame(8'h56, 8'hA2, 1, 8'h2A, r);
    cmd_frame(8'h72, 8'hD9, 0, 8'h00, r);
    drained("R3");

    // R7: read wiper channel 3 and slot 2 of channel 0
    cur_req = "R7";
    fbegin();
    send_byte(ADDR_OK, r);
    send_byte(8'h93, r);
    sck_bit(1'b0, s);
    chk(so_oe == 1'b1, "R7 oe during reply", so_oe, 1);
    r[7] = s;
    for (int i = 6; i >= 0; i--) begin
      sck_bit(1'b0, s);
      r[i] = s;
    end
    fend();
    chk(r == 8'h1F, "R7 wiper reply", r, 8'h1F);
    chk(so_oe == 1'b0, "R7 oe after frame", so_oe, 0);
    cmd_frame(ADDR_OK, 8'hB8, 1, 8'h00, r);
    chk(r == 8'h0B, "R7 slot reply", r, 8'h0B);

    // R8: status
    cur_req = "R8";
    wip = 1'b1;
    cmd_frame(ADDR_OK, 8'h51, 1, 8'h00, r);
    chk(r == 8'h01, "R8 status busy", r, 8'h01);
    wip = 1'b0;
    cmd_frame(ADDR_OK, 8'h51, 1, 8'h00, r);
    chk(r == 8'h00, "R8 status idle", r, 8'h00);

    // R5 R4: transfers, single and global
    cur_req = "R5";
    expect_act(2, 0, 1, 2, 0);
    cmd_frame(ADDR_OK, 8'hD9, 0, 8'h00, r);
    expect_act(3, 0, 3, 1, 0);
    cmd_frame(ADDR_OK, 8'hE7, 0, 8'h00, r);
    expect_act(2, 1, 0, 3, 0);
    cmd_frame(ADDR_OK, 8'h1C, 0, 8'h00, r);
    expect_act(3, 1, 0, 0, 0);
    cmd_frame(ADDR_OK, 8'h80, 0, 8'h00, r);
    drained("R5");

    // R9: stepping on channel 2
    cur_req = "R9";
    fbegin();
    send_byte(ADDR_OK, r);
    send_byte(8'h22, r);
    expect_act(4, 0, 2, 0, 0);
    expect_act(4, 0, 2, 0, 0);
    expect_act(5, 0, 2, 0, 0);
    expect_act(4, 0, 2, 0, 0);
    expect_act(5, 0, 2, 0, 0);
    sck_bit(1, s); sck_bit(1, s); sck_bit(0, s); sck_bit(1, s); sck_bit(0, s);
    fend();
    drained("R9");

    // R11: unknown opcode, then a truncated load
    cur_req = "R11";
    cmd_frame(ADDR_OK, 8'h31, 1, 8'h2A, r);
    fbegin();
    send_byte(ADDR_OK, r);
    send_byte(8'hA2, r);
    for (int i = 0; i < 5; i++) sck_bit(1'b1, s);
    fend();
    drained("R11");

    // R10: pause mid data byte with junk clocks
    cur_req = "R10";
    expect_act(1, 0, 1, 2, 6'h33);
    fbegin();
    send_byte(ADDR_OK, r);
    send_byte(8'hC9, r);
    sck_bit(0, s); sck_bit(0, s); sck_bit(1, s);
    wait_clk(4);
    hold_n = 1'b0;
    wait_clk(4);
    sck_bit(1, s); sck_bit(0, s); sck_bit(1, s);
    hold_n = 1'b1;
    wait_clk(4);
    sck_bit(1, s); sck_bit(0, s); sck_bit(0, s); sck_bit(1, s); sck_bit(1, s);
    fend();
    drained("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule